// File: doc/BRIEF.md
# Flash Busy-Status Read Generator

This block produces the byte a parallel NOR flash hands back when the host reads it. While an internal program or erase is running, the read returns status instead of array data. The top bit is a polling bit. During a program it is the inverse of the top bit of the byte being written, and during an erase it is 0. The next bit down is a toggle bit that flips on every read while the operation runs. All other bits read as 0. Once the device is idle, a read returns the stored array byte supplied from outside.

An internal operation starts only when a launch request arrives at the right point in its command. A program launch needs four completed write pulses and an erase launch needs six. Any other request is ignored and status never becomes valid. A countdown timer stands in for the internal operation time, with separate lengths for program and erase. Array storage and command decoding stay outside the block. The launch request, the write-pulse count and the array byte are inputs.

Top module: `fsr_status_gen`

## Requirements
- R1: After reset, and at once whenever rst_n is pulled low (even in the middle of an operation), `rd_data` is 0x00 and `busy` is 0.
- R2: A launch starts an operation only when `busy` is 0 and the write-pulse count matches the operation. `op_kind`=0 (program) needs a count of exactly 4. `op_kind`=1 (erase) needs a count of exactly 6. Any other request leaves `busy` at 0.
- R3: `busy` rises on the clock edge that accepts a launch. It stays high for exactly PROG_CYCLES cycles for a program and ERASE_CYCLES cycles for an erase.
- R4: During a program, status bit DATA_W-1 (bit 7) is the inverse of `prog_msb` as sampled at launch. Later changes on `prog_msb` have no effect.
- R5: During an erase, status bit 7 is 0.
- R6: The toggle bit (bit 6) is cleared when an operation starts. The first status read of the operation returns 1, and each further read returns the opposite of the one before. A strobe held high counts as a single read.
- R7: Status reads drive bits 5..0 to 0.
- R8: A read while `busy` is 0 returns `array_data` as it was on the strobe's rising edge.
- R9: `rd_data` is updated only on the clock after a 0-to-1 change of `rd_strobe`. At all other times it holds its value, even if `array_data` changes.
- R10: A launch request while `busy` is 1 is ignored. The running operation is not restarted and its length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_launch | input | 1 | Request to start the internal operation |
| op_kind | input | 1 | 0 = program, 1 = erase |
| pulse_cnt | input | PULSE_W (3) | Write pulses completed in the current command |
| prog_msb | input | 1 | Top bit of the byte being programmed |
| rd_strobe | input | 1 | Read strobe, one read per rising edge |
| array_data | input | DATA_W (8) | Stored array byte returned when idle |
| rd_data | output | DATA_W (8) | Read data bus |
| busy | output | 1 | Internal operation in progress |

## Verification
A table of launch requests pairs each operation type with correct and wrong pulse counts. It separates a gate that checks the exact count from one that checks at-least, or one that mixes up the two thresholds. Status reads are tried with both values of the programmed top bit, during an erase, and with `prog_msb` changed mid-operation. These reads tell inversion from pass-through, show the erase case as fixed, and show whether the value was latched at launch. A strobe held over several cycles shows whether the toggle bit follows edges rather than levels. The toggle bit is also read at the start of a second operation to confirm it was cleared. Busy lengths are measured for each operation type, with and without a relaunch in the middle. These runs expose an off-by-one count or a timer that restarts.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;

  // write pulses that must be complete before status becomes valid
  localparam int unsigned PROG_PULSES  = 4;
  localparam int unsigned ERASE_PULSES = 6;

endpackage

// File: rtl/fsr_rst_sync.sv
module fsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/fsr_launch_gate.sv
module fsr_launch_gate
  import fsr_pkg::*;
#(
  parameter int unsigned PULSE_W = 3
) (
  input  logic               op_launch,
  input  logic               op_kind,
  input  logic [PULSE_W-1:0] pulse_cnt,
  input  logic               busy,
  output logic               launch_ok
);

  localparam logic [PULSE_W-1:0] NEED_PROG  = PULSE_W'(PROG_PULSES);
  localparam logic [PULSE_W-1:0] NEED_ERASE = PULSE_W'(ERASE_PULSES);

  logic [PULSE_W-1:0] need;
  logic               count_match;

  always_comb begin
    need        = (op_kind == OP_ERASE) ? NEED_ERASE : NEED_PROG;
    count_match = (pulse_cnt == need);
    launch_ok   = op_launch && !busy && count_match;
  end

endmodule

// File: rtl/fsr_op_timer.sv
module fsr_op_timer
  import fsr_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 40,
  parameter int unsigned ERASE_CYCLES = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic op_kind,
  output logic busy
);

  localparam int unsigned MAX_C  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] LOAD_PROG  = CNT_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0] LOAD_ERASE = CNT_W'(ERASE_CYCLES);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = load || busy;
    if (load) begin
      cnt_d = (op_kind == OP_ERASE) ? LOAD_ERASE : LOAD_PROG;
    end else if (busy) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fsr_read_mux.sv
module fsr_read_mux
  import fsr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              op_kind,
  input  logic              prog_msb,
  input  logic              busy,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned POLL_BIT = DATA_W - 1;
  localparam int unsigned TOG_BIT  = DATA_W - 2;

  logic              strobe_q;
  logic              tog_q,  tog_d;
  logic              poll_q, poll_d;
  logic [DATA_W-1:0] rd_q,   rd_d;
  logic              rd_rise;
  logic              ctx_en;
  logic [DATA_W-1:0] status_word;

  assign rd_rise = rd_strobe && !strobe_q;
  assign rd_data = rd_q;

  always_comb begin
    status_word           = '0;
    status_word[POLL_BIT] = poll_q;
    status_word[TOG_BIT]  = ~tog_q;
  end

  // operation context: polling value and toggle state
  always_comb begin
    tog_d  = tog_q;
    poll_d = poll_q;
    ctx_en = launch || (rd_rise && busy);
    if (launch) begin
      tog_d  = 1'b0;
      poll_d = (op_kind == OP_ERASE) ? 1'b0 : ~prog_msb;
    end else if (rd_rise && busy) begin
      tog_d  = ~tog_q;
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_rise) begin
      rd_d = busy ? status_word : array_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= rd_strobe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= 1'b0;
      poll_q <= 1'b0;
    end else if (ctx_en) begin
      tog_q  <= tog_d;
      poll_q <= poll_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_rise) begin
      rd_q <= rd_d;
    end
  end

endmodule

// File: rtl/fsr_status_gen.sv
module fsr_status_gen #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned PULSE_W      = 3,
  parameter int unsigned PROG_CYCLES  = 40,
  parameter int unsigned ERASE_CYCLES = 120
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_launch,
  input  logic               op_kind,
  input  logic [PULSE_W-1:0] pulse_cnt,
  input  logic               prog_msb,
  input  logic               rd_strobe,
  input  logic [DATA_W-1:0]  array_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               busy
);

  logic rst_n_int;
  logic launch_ok;

  fsr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  fsr_launch_gate #(.PULSE_W(PULSE_W)) u_gate (
    .op_launch (op_launch),
    .op_kind   (op_kind),
    .pulse_cnt (pulse_cnt),
    .busy      (busy),
    .launch_ok (launch_ok)
  );

  fsr_op_timer #(
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load    (launch_ok),
    .op_kind (op_kind),
    .busy    (busy)
  );

  fsr_read_mux #(.DATA_W(DATA_W)) u_mux (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .launch     (launch_ok),
    .op_kind    (op_kind),
    .prog_msb   (prog_msb),
    .busy       (busy),
    .rd_strobe  (rd_strobe),
    .array_data (array_data),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/fsr_status_gen_chk.sv
module fsr_status_gen_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PULSE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_launch,
  input logic               op_kind,
  input logic [PULSE_W-1:0] pulse_cnt,
  input logic               rd_strobe,
  input logic [DATA_W-1:0]  array_data,
  input logic [DATA_W-1:0]  rd_data,
  input logic               busy
);

  localparam logic [PULSE_W-1:0] P_PROG  = PULSE_W'(4);
  localparam logic [PULSE_W-1:0] P_ERASE = PULSE_W'(6);

  logic strobe_seen;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_seen <= 1'b0;
    end else begin
      strobe_seen <= rd_strobe;
    end
  end

  assign rise = rd_strobe && !strobe_seen;

  // R2: an operation begins only after a correctly counted launch
  p_launch_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(op_launch && (op_kind ? (pulse_cnt == P_ERASE) : (pulse_cnt == P_PROG))));

  // R3: an operation never lasts a single cycle (both lengths are at least 2)
  p_busy_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  // R7: low bits of a status read are zero
  p_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && busy) |=> (rd_data[DATA_W-3:0] == '0));

  // R8: idle reads return the array byte
  p_idle_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !busy) |=> (rd_data == $past(array_data)));

  // R9: the bus holds between reads
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(rd_data));

endmodule

bind fsr_status_gen fsr_status_gen_chk #(
  .DATA_W  (DATA_W),
  .PULSE_W (PULSE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_launch  (op_launch),
  .op_kind    (op_kind),
  .pulse_cnt  (pulse_cnt),
  .rd_strobe  (rd_strobe),
  .array_data (array_data),
  .rd_data    (rd_data),
  .busy       (busy)
);

// File: tb/fsr_status_gen_bench.sv
`timescale 1ns/1ps
module fsr_status_gen_bench;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned PULSE_W = 3;
  localparam int unsigned T_PROG  = 40;
  localparam int unsigned T_ERASE = 80;

  logic               clk;
  logic               rst_n;
  logic               op_launch;
  logic               op_kind;
  logic [PULSE_W-1:0] pulse_cnt;
  logic               prog_msb;
  logic               rd_strobe;
  logic [DATA_W-1:0]  array_data;
  logic [DATA_W-1:0]  rd_data;
  logic               busy;

  int n_checks;
  int n_fail;
  bit done;

  fsr_status_gen #(
    .DATA_W       (DATA_W),
    .PULSE_W      (PULSE_W),
    .PROG_CYCLES  (T_PROG),
    .ERASE_CYCLES (T_ERASE)
  ) u_fsr_status_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_launch  (op_launch),
    .op_kind    (op_kind),
    .pulse_cnt  (pulse_cnt),
    .prog_msb   (prog_msb),
    .rd_strobe  (rd_strobe),
    .array_data (array_data),
    .rd_data    (rd_data),
    .busy       (busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {kind, pulses[2:0], accepted}
  localparam logic [4:0] VEC [8] = '{
    {1'b0, 3'd4, 1'b1},
    {1'b0, 3'd3, 1'b0},
    {1'b0, 3'd6, 1'b0},
    {1'b1, 3'd6, 1'b1},
    {1'b1, 3'd4, 1'b0},
    {1'b1, 3'd5, 1'b0},
    {1'b0, 3'd0, 1'b0},
    {1'b1, 3'd7, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic launch(input logic kind, input logic [PULSE_W-1:0] pulses);
    op_kind   = kind;
    pulse_cnt = pulses;
    op_launch = 1'b1;
    @(negedge clk);
    op_launch = 1'b0;
  endtask

  task automatic read_once();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask

  task automatic measure(input int relaunch_at, output int n);
    n = 0;
    while (busy && n < 1000) begin
      op_launch = (n == relaunch_at);
      n++;
      @(negedge clk);
    end
    op_launch = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      summary();
    end
  end

  initial begin
    int n;
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; op_launch = 1'b0; op_kind = 1'b0; pulse_cnt = '0;
    prog_msb = 1'b0; rd_strobe = 1'b0; array_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset rd_data", rd_data, 8'h00);
    chk("R1 reset busy", busy, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table of launch requests (R2)
    foreach (VEC[i]) begin
      launch(VEC[i][4], VEC[i][3:1]);
      chk("R2 launch gate", busy, VEC[i][0]);
      wait_idle();
    end

    // program with top bit 1: polling reads 0, toggle 1,0,1 (R4 R6 R7)
    prog_msb = 1'b1;
    launch(1'b0, 3'd4);
    read_once(); chk("R4 R6 R7 first program read", rd_data, 8'h40);
    prog_msb = 1'b0;
    read_once(); chk("R4 R6 latched polling, second read", rd_data, 8'h00);
    read_once(); chk("R6 third read", rd_data, 8'h40);
    wait_idle();
    array_data = 8'hA5;
    read_once(); chk("R8 idle read after program", rd_data, 8'hA5);

    // erase: polling 0; toggle restarts from cleared state (R5 R6)
    launch(1'b1, 3'd6);
    read_once(); chk("R5 R6 first erase read", rd_data, 8'h40);
    read_once(); chk("R5 second erase read", rd_data, 8'h00);
    read_once(); chk("R5 third erase read", rd_data, 8'h40);
    wait_idle();
    array_data = 8'hFF;
    read_once(); chk("R8 idle read after erase", rd_data, 8'hFF);

    // program with top bit 0; held strobe is one read (R4 R6)
    prog_msb = 1'b0;
    launch(1'b0, 3'd4);
    rd_strobe = 1'b1;
    repeat (3) @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
    chk("R4 R6 held strobe single read", rd_data, 8'hC0);
    read_once(); chk("R6 next read flips", rd_data, 8'h80);
    wait_idle();

    // hold between reads (R9)
    array_data = 8'h3C;
    read_once(); chk("R8 idle read", rd_data, 8'h3C);
    array_data = 8'h99;
    repeat (4) @(negedge clk);
    chk("R9 bus held without strobe", rd_data, 8'h3C);

    // operation lengths (R3)
    launch(1'b0, 3'd4);
    measure(-1, n); chk("R3 program length", n, T_PROG);
    launch(1'b1, 3'd6);
    measure(-1, n); chk("R3 erase length", n, T_ERASE);

    // relaunch while busy ignored (R10)
    op_kind = 1'b0; pulse_cnt = 3'd4;
    launch(1'b0, 3'd4);
    measure(5, n); chk("R10 relaunch ignored", n, T_PROG);

    // reset in the middle of an operation (R1)
    launch(1'b1, 3'd6);
    read_once();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-op reset busy", busy, 1'b0);
    chk("R1 mid-op reset rd_data", rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 stays idle after reset", busy, 1'b0);

    done = 1'b1;
    summary();
  end

endmodule